// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block finds the divider settings for a phase-locked loop that bring its output as close as possible to a requested frequency. A single start pulse supplies four values: the reference frequency in kHz, the wanted output in kHz, and the slowest and fastest allowed lane rates in kbps. The lane limits set the window the oscillator may run in. The engine then tries every pre-divider from 1 to 7. For each pre-divider it tries the post-dividers 1, 2, 4 and 8 in that order, and picks the nearest multiplier for each pair. It keeps the pair and multiplier whose rounded output lands nearest the target.

All arithmetic runs through one shared bit-serial divider. Each quotient therefore costs roughly one cycle per bit of the internal width, and a full search takes a few thousand cycles. When the search ends, `done` pulses for one cycle. The chosen pre-divider, multiplier, post-divider and resulting frequency then stay on the outputs until the next accepted start. Flags report a rejected request or a search that found no usable setting.

Top module: `pll_div_search`

## Requirements
- R1: After reset `busy`, `done`, `bad_input` and `no_solution` are 0, and `idf_o`, `ndiv_o`, `odf_o` and `fout_khz` are 0.
- R2: A start taken while idle is refused when the reference or the target, read as a two's-complement number, is zero or negative. In that case `done` is 1 in the cycle after the start, together with `bad_input` = 1 and all result outputs 0. `busy` stays 0.
- R3: For each pre-divider i (1..7), the multiplier window runs from lo = floor(lane_min·16·i / (2·ref)) + 1 up to hi = floor(lane_max·2·i / (2·ref)). lo is raised to at least 10 and hi is lowered to at most 125. For each post-divider o, the candidate multiplier is round(i·o·target / ref). A candidate outside [lo, hi] is skipped.
- R4: `fout_khz` equals round-to-nearest of ref·`ndiv_o` / (`idf_o`·`odf_o`), where rounding adds half the divisor (truncated) before dividing.
- R5: The stored best error starts at 1,000,000 kHz. A candidate replaces the stored result only when its absolute error is strictly smaller. Pre-dividers are tried in ascending order, and post-dividers 1, 2, 4, 8 in ascending order within each pre-divider. The first candidate with zero error ends the search and is the reported result.
- R6: If the unclamped lo for the current pre-divider is 125 or more, no larger pre-divider is tried.
- R7: If no candidate was ever stored, `no_solution` is 1 when `done` pulses, and `idf_o`, `ndiv_o`, `odf_o` and `fout_khz` are 0.
- R8: A start pulse while `busy` is 1 has no effect on the search or on its result.
- R9: `done` is high for exactly one cycle. `busy` is 1 from the cycle after an accepted start until the cycle in which `done` rises.
- R10: On a successful search, `idf_o` holds the pre-divider value (1..7), `ndiv_o` the multiplier value (10..125), and `odf_o` the post-divider value itself (1, 2, 4 or 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search with the values present in this cycle |
| clkin_khz | input | W | Reference frequency, kHz, two's complement |
| target_khz | input | W | Requested output frequency, kHz, two's complement |
| lane_min_kbps | input | W | Lowest allowed lane rate, kbps |
| lane_max_kbps | input | W | Highest allowed lane rate, kbps |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_input | output | 1 | Last request was refused |
| no_solution | output | 1 | Last search stored no candidate |
| idf_o | output | 3 | Chosen pre-divider |
| ndiv_o | output | 7 | Chosen loop multiplier |
| odf_o | output | 4 | Chosen post-divider value |
| fout_khz | output | W+8 | Output frequency of the chosen setting, kHz |

## Verification
The bench sweeps several reference and target frequencies against two lane-rate windows and compares each result with an arithmetic model of the search rules. If the design replaced the best on ties, or tried the loops in another order, these runs would return a different triple. A reference of 24000 kHz with a 480000 kHz target has an exact match at the first pair. A design that kept searching after it, or rounded with the wrong half-divisor, would report another setting or frequency. A tiny reference trips the early exit, and a huge one leaves every window empty. A design that mishandled either would report a setting instead of the no-solution flag with zero outputs. Zero and negative requests, and a second start during a search, confirm that refused or stray pulses change nothing.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
    localparam int IDF_LO        = 1;
    localparam int IDF_HI        = 7;
    localparam int NDIV_LO       = 10;
    localparam int NDIV_HI       = 125;
    localparam int ODF_LO        = 1;
    localparam int ODF_HI        = 8;
    localparam int VCO_LO_SCALE  = 16;
    localparam int VCO_HI_SCALE  = 2;
    localparam int BEST_INIT     = 1000000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WIN_LO,
        PH_WIN_HI,
        PH_CAND,
        PH_FREQ,
        PH_STEP,
        PH_FINISH
    } phase_e;

    typedef struct packed {
        logic [2:0] idf;
        logic [6:0] ndiv;
        logic [3:0] odf;
    } triple_t;

    function automatic logic is_nonpositive(input logic [63:0] v, input int width);
        logic neg;
        neg = v[width-1];
        return neg || (v == '0);
    endfunction
endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int PW = 40,
    localparam int CW = $clog2(PW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [PW-1:0] dividend,
    input  logic [PW-1:0] divisor,
    output logic          done,
    output logic [PW-1:0] quotient
);
    logic [PW:0]   rem_q;
    logic [PW-1:0] quo_q;
    logic [PW-1:0] dsr_q;
    logic [PW-1:0] orig_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [PW:0]   shifted;
    logic [PW+1:0] trial;

    assign shifted  = {rem_q[PW-1:0], quo_q[PW-1]};
    assign trial    = {1'b0, shifted} - {2'b00, dsr_q};
    assign quotient = quo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dsr_q  <= '0;
            orig_q <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                orig_q <= dividend;
                dsr_q  <= divisor;
                rem_q  <= '0;
                cnt_q  <= CW'(PW);
                if (divisor == '0) begin
                    quo_q <= '0;
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end else begin
                    quo_q <= dividend;
                    run_q <= 1'b1;
                end
            end else if (run_q) begin
                if (!trial[PW+1]) begin
                    rem_q <= trial[PW:0];
                    quo_q <= {quo_q[PW-2:0], 1'b1};
                end else begin
                    rem_q <= shifted;
                    quo_q <= {quo_q[PW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    // R4: every finished quotient is the floor of dividend over divisor
    assert_quotient_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (done && dsr_q != '0) |->
            ((2*PW)'(quo_q) * (2*PW)'(dsr_q) <= (2*PW)'(orig_q)) &&
            ((2*PW)'(orig_q) < ((2*PW)'(quo_q) + 1) * (2*PW)'(dsr_q)));
endmodule

// File: rtl/err_judge.sv
module err_judge #(
    parameter int PW = 40
) (
    input  logic [PW-1:0] fout,
    input  logic [PW-1:0] target,
    input  logic [PW-1:0] best,
    output logic [PW-1:0] delta,
    output logic          better,
    output logic          exact
);
    always_comb begin
        delta  = (fout >= target) ? (fout - target) : (target - fout);
        better = delta < best;
        exact  = (delta == '0);
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int W = 32,
    localparam int PW = W + 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  clkin_khz,
    input  logic [W-1:0]  target_khz,
    input  logic [W-1:0]  lane_min_kbps,
    input  logic [W-1:0]  lane_max_kbps,
    output logic          busy,
    output logic          done,
    output logic          bad_input,
    output logic          no_solution,
    output logic [2:0]    idf_o,
    output logic [6:0]    ndiv_o,
    output logic [3:0]    odf_o,
    output logic [PW-1:0] fout_khz
);
    phase_e        ph_q;
    logic          issued_q;
    logic [PW-1:0] ck_q, tg_q, vlo_q, vhi_q, best_q;
    logic [2:0]    idf_c;
    logic [3:0]    odf_c;
    logic [6:0]    nlo_q, nhi_q, ncand_q;
    logic          found_q;
    triple_t       res_q;

    logic          div_go, div_done;
    logic [PW-1:0] div_dvd, div_dsr, div_q;
    logic [PW-1:0] idf_w, odf_w, prod_w, delta;
    logic          better, exact, req_bad;

    assign idf_w  = PW'(idf_c);
    assign odf_w  = PW'(odf_c);
    assign prod_w = idf_w * odf_w;
    assign busy   = (ph_q != PH_IDLE);
    assign idf_o  = res_q.idf;
    assign ndiv_o = res_q.ndiv;
    assign odf_o  = res_q.odf;
    assign req_bad = is_nonpositive(64'(clkin_khz), W) || is_nonpositive(64'(target_khz), W);

    always_comb begin
        div_dvd = '0;
        div_dsr = '0;
        unique case (ph_q)
            PH_WIN_LO: begin div_dvd = vlo_q * idf_w; div_dsr = ck_q << 1; end
            PH_WIN_HI: begin div_dvd = vhi_q * idf_w; div_dsr = ck_q << 1; end
            PH_CAND:   begin div_dvd = tg_q * prod_w + (ck_q >> 1); div_dsr = ck_q; end
            PH_FREQ:   begin div_dvd = ck_q * PW'(ncand_q) + (prod_w >> 1); div_dsr = prod_w; end
            default:   begin div_dvd = '0; div_dsr = '0; end
        endcase
        div_go = !issued_q && (ph_q == PH_WIN_LO || ph_q == PH_WIN_HI ||
                               ph_q == PH_CAND   || ph_q == PH_FREQ);
    end

    seq_divider #(.PW(PW)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .dividend(div_dvd),
        .divisor(div_dsr), .done(div_done), .quotient(div_q)
    );

    err_judge #(.PW(PW)) u_judge (
        .fout(div_q), .target(tg_q), .best(best_q),
        .delta(delta), .better(better), .exact(exact)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE; issued_q <= 1'b0;
            ck_q <= '0; tg_q <= '0; vlo_q <= '0; vhi_q <= '0; best_q <= '0;
            idf_c <= '0; odf_c <= '0; nlo_q <= '0; nhi_q <= '0; ncand_q <= '0;
            found_q <= 1'b0; res_q <= '0; fout_khz <= '0;
            done <= 1'b0; bad_input <= 1'b0; no_solution <= 1'b0;
        end else begin
            done <= 1'b0;
            if (div_go) issued_q <= 1'b1;
            if (div_done) issued_q <= 1'b0;
            unique case (ph_q)
                PH_IDLE: if (start) begin
                    res_q       <= '0;
                    fout_khz    <= '0;
                    no_solution <= 1'b0;
                    if (req_bad) begin
                        bad_input <= 1'b1;
                        done      <= 1'b1;
                    end else begin
                        bad_input <= 1'b0;
                        ck_q      <= PW'(clkin_khz);
                        tg_q      <= PW'(target_khz);
                        vlo_q     <= PW'(lane_min_kbps) * PW'(VCO_LO_SCALE);
                        vhi_q     <= PW'(lane_max_kbps) * PW'(VCO_HI_SCALE);
                        best_q    <= PW'(BEST_INIT);
                        found_q   <= 1'b0;
                        idf_c     <= 3'(IDF_LO);
                        odf_c     <= 4'(ODF_LO);
                        ph_q      <= PH_WIN_LO;
                    end
                end
                PH_WIN_LO: if (div_done) begin
                    if (div_q + 1'b1 >= PW'(NDIV_HI)) begin
                        ph_q <= PH_FINISH;
                    end else begin
                        nlo_q <= (div_q + 1'b1 < PW'(NDIV_LO)) ? 7'(NDIV_LO) : 7'(div_q + 1'b1);
                        ph_q  <= PH_WIN_HI;
                    end
                end
                PH_WIN_HI: if (div_done) begin
                    nhi_q <= (div_q > PW'(NDIV_HI)) ? 7'(NDIV_HI) : 7'(div_q);
                    odf_c <= 4'(ODF_LO);
                    ph_q  <= PH_CAND;
                end
                PH_CAND: if (div_done) begin
                    if (div_q < PW'(nlo_q) || div_q > PW'(nhi_q)) begin
                        ph_q <= PH_STEP;
                    end else begin
                        ncand_q <= 7'(div_q);
                        ph_q    <= PH_FREQ;
                    end
                end
                PH_FREQ: if (div_done) begin
                    if (better) begin
                        best_q   <= delta;
                        res_q    <= '{idf: idf_c, ndiv: ncand_q, odf: odf_c};
                        fout_khz <= div_q;
                        found_q  <= 1'b1;
                    end
                    ph_q <= exact ? PH_FINISH : PH_STEP;
                end
                PH_STEP: begin
                    if (odf_c == 4'(ODF_HI)) begin
                        if (idf_c == 3'(IDF_HI)) begin
                            ph_q <= PH_FINISH;
                        end else begin
                            idf_c <= idf_c + 1'b1;
                            ph_q  <= PH_WIN_LO;
                        end
                    end else begin
                        odf_c <= odf_c << 1;
                        ph_q  <= PH_CAND;
                    end
                end
                PH_FINISH: begin
                    done        <= 1'b1;
                    no_solution <= !found_q;
                    ph_q        <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_inputs_held_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(tg_q) && $stable(ck_q) && $stable(vlo_q) && $stable(vhi_q)));

    assert_best_never_grows_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> (best_q <= $past(best_q)));

    assert_result_range_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !no_solution && !bad_input) |->
            (idf_o >= 3'(IDF_LO) && idf_o <= 3'(IDF_HI) &&
             ndiv_o >= 7'(NDIV_LO) && ndiv_o <= 7'(NDIV_HI) &&
             $onehot(odf_o)));

    assert_nosol_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (done && no_solution) |->
            (idf_o == '0 && ndiv_o == '0 && odf_o == '0 && fout_khz == '0));

    assert_refuse_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && req_bad) |=> (done && bad_input && !busy));
endmodule

// File: tb/pll_div_search_test.sv
module pll_div_search_test;
    localparam int W  = 24;
    localparam int PW = W + 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  clkin_khz = '0, target_khz = '0, lane_min_kbps = '0, lane_max_kbps = '0;
    logic          busy, done, bad_input, no_solution;
    logic [2:0]    idf_o;
    logic [6:0]    ndiv_o;
    logic [3:0]    odf_o;
    logic [PW-1:0] fout_khz;

    int checks = 0;
    int errors = 0;

    longint e_i, e_n, e_o, e_f;
    bit     e_none;

    always #5 clk = ~clk;

    pll_div_search #(.W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .clkin_khz(clkin_khz),
        .target_khz(target_khz), .lane_min_kbps(lane_min_kbps),
        .lane_max_kbps(lane_max_kbps), .busy(busy), .done(done),
        .bad_input(bad_input), .no_solution(no_solution), .idf_o(idf_o),
        .ndiv_o(ndiv_o), .odf_o(odf_o), .fout_khz(fout_khz)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input longint ck, input longint tg, input longint lmin, input longint lmax);
        longint best, vlo, vhi, nlo, nhi, n, f, d;
        bit stop;
        e_i = 0; e_n = 0; e_o = 0; e_f = 0; e_none = 1;
        best = 1000000; vlo = lmin * 16; vhi = lmax * 2; stop = 0;
        for (int i = 1; i <= 7 && !stop; i++) begin
            nlo = (vlo * i) / (2 * ck) + 1;
            nhi = (vhi * i) / (2 * ck);
            if (nlo >= 125) begin
                stop = 1;
            end else begin
                if (nlo < 10) nlo = 10;
                if (nhi > 125) nhi = 125;
                for (int o = 1; o <= 8 && !stop; o = o * 2) begin
                    n = (i * o * tg + ck / 2) / ck;
                    if (n >= nlo && n <= nhi) begin
                        f = (ck * n + (i * o) / 2) / (i * o);
                        d = (f >= tg) ? f - tg : tg - f;
                        if (d < best) begin
                            best = d; e_i = i; e_n = n; e_o = o; e_f = f; e_none = 0;
                        end
                        if (d == 0) stop = 1;
                    end
                end
            end
        end
    endtask

    task automatic pulse_start(input longint ck, input longint tg, input longint lmin, input longint lmax);
        clkin_khz = W'(ck); target_khz = W'(tg);
        lane_min_kbps = W'(lmin); lane_max_kbps = W'(lmax);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int k = 0; k < 6000 && !seen; k++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
    endtask

    task automatic compare_result(input longint ck, input string tag);
        check(idf_o == 3'(e_i), {tag, " R3 idf"}, idf_o, e_i);
        check(ndiv_o == 7'(e_n), {tag, " R3 ndiv"}, ndiv_o, e_n);
        check(odf_o == 4'(e_o), {tag, " R10 odf"}, odf_o, e_o);
        check(no_solution == e_none, {tag, " R7 no_solution"}, no_solution, e_none);
        check(fout_khz == PW'(e_f), {tag, " R4 fout"}, fout_khz, e_f);
        if (!e_none)
            check(fout_khz == PW'((ck * ndiv_o + (idf_o * odf_o) / 2) / (idf_o * odf_o)),
                  {tag, " R4 rounding"}, fout_khz, (ck * ndiv_o + (idf_o * odf_o) / 2) / (idf_o * odf_o));
    endtask

    task automatic run_case(input longint ck, input longint tg, input longint lmin, input longint lmax, input string tag);
        bit seen;
        model(ck, tg, lmin, lmax);
        pulse_start(ck, tg, lmin, lmax);
        check(busy == 1'b1, {tag, " R9 busy after start"}, busy, 1);
        wait_done(seen);
        check(seen, {tag, " R9 done seen (watchdog)"}, seen, 1);
        if (seen) begin
            compare_result(ck, tag);
            @(negedge clk);
            check(done == 1'b0 && busy == 1'b0, {tag, " R9 single pulse"}, done, 0);
        end
    endtask

    task automatic refused(input longint ck, input longint tg, input string tag);
        pulse_start(ck, tg, 31250, 500000);
        check(done && bad_input, {tag, " R2 refused"}, {done, bad_input}, 3);
        check(!busy, {tag, " R2 no search"}, busy, 0);
        check(idf_o == 0 && ndiv_o == 0 && odf_o == 0 && fout_khz == 0, {tag, " R2 outputs zero"}, fout_khz, 0);
        @(negedge clk);
    endtask

    initial begin
        #1900000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint cks[4] = '{19200, 24000, 27000, 26000};
        longint tgs[4] = '{62500, 250000, 480000, 497000};
        bit seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !bad_input && !no_solution, "R1 flags after reset",
              {busy, done, bad_input, no_solution}, 0);
        check(idf_o == 0 && ndiv_o == 0 && odf_o == 0 && fout_khz == 0, "R1 outputs after reset", fout_khz, 0);

        refused(0, 250000, "zero ref");
        refused(24000, 0, "zero target");
        refused(24000, -5, "negative target");
        refused(-100, 250000, "negative ref");

        run_case(24000, 480000, 31250, 500000, "R5 exact first pair");
        check(idf_o == 1 && ndiv_o == 20 && odf_o == 1, "R5 exact triple", ndiv_o, 20);

        run_case(1000, 250000, 31250, 500000, "R6 early stop");
        check(no_solution == 1'b1, "R6 flagged no solution", no_solution, 1);
        run_case(1000000, 500000, 31250, 500000, "R7 empty windows");
        check(no_solution == 1'b1 && fout_khz == 0, "R7 zero outputs", fout_khz, 0);

        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                run_case(cks[a], tgs[b], 31250, 500000, "R3 sweep narrow");
                run_case(cks[a], tgs[b] * 2, 62500, 1000000, "R3 sweep wide");
            end

        model(26000, 333333, 31250, 500000);
        pulse_start(26000, 333333, 31250, 500000);
        repeat (50) @(negedge clk);
        pulse_start(24000, 480000, 31250, 500000);
        check(busy == 1'b1, "R8 still busy after stray start", busy, 1);
        wait_done(seen);
        check(seen, "R8 done seen", seen, 1);
        if (seen) compare_result(26000, "R8 stray start ignored");
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule